// File: doc/BRIEF.md
# Channel Status, User and Validity Bit Capture Buffer

This block supplies the three per-subframe side bits (channel status, user, validity) to a serial digital audio transmitter that runs with no host controller. It watches an asynchronous word clock and, on every edge of that clock, loads one subframe's worth of side bits. These appear on registered outputs along with a one-cycle strobe, a left/right flag and a block-start marker. A downstream encoder reads all of them.

A mode pin picks where the channel status bit comes from. In built mode, a 192-bit consumer-format channel status word is assembled from four static configuration pins and played out one bit per frame. In serial mode, the channel status bit is taken from a pin on each word clock edge, just like the user and validity bits. In that case the block-start marker tells the external source which frame carries status bit 0.

Top module: `csuv_capture`

## Requirements
- R1: After a synchronous active-low reset, `c_bit`, `u_bit`, `v_bit`, `sub_right`, `blk_start` and `bit_stb` are 0. They stay 0 until the first rising word clock edge. A falling edge that comes before that first rising edge is ignored.
- R2: Each word clock edge gives exactly one one-cycle `bit_stb` pulse. The outputs change on the third system clock edge after the word clock transition. A rising edge loads the left subframe (`sub_right`=0) and a falling edge loads the right subframe (`sub_right`=1).
- R3: When `serial_mode`=1 at an edge, `c_bit` equals `copy_c` as sampled at that edge.
- R4: In both modes, `u_bit` and `v_bit` equal `u_in` and `v_in` as sampled at the edge.
- R5: A frame index counts rising edges and takes the values 0 to 191. It is 0 at the first rising edge after reset and wraps from 191 back to 0. `blk_start` is 1 for both subframes of frame 0 and 0 for all other frames.
- R6: The built status word has these fields. Bit 0 is 0. Bit 1 = `non_audio`. Bit 2 = `copy_c` (copying permitted). Bits 3..5 = 3'b001 in index order (bit 3 set) when `emph` is 1, and 0 otherwise. The category code in bits 8..15 is 0, except that bit 15 = `orig`. Every other bit is 0.
- R7: When `serial_mode`=0 at an edge, `c_bit` is bit N of the built word, where N is the current frame index. The left and right subframes of a frame carry the same bit.
- R8: The built word is rebuilt from `copy_c`, `orig`, `emph` and `non_audio` only at the rising edge that starts frame 0, whatever the mode. Changes to those pins at any other time have no effect until the next frame 0.
- R9: `serial_mode` is sampled at every edge, so a mode change takes effect from the next subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_clk | input | 1 | Asynchronous input word clock, high for left subframe |
| serial_mode | input | 1 | 1 = channel status taken serially, 0 = built from pins |
| copy_c | input | 1 | Serial channel status bit, or copy-permitted flag in built mode |
| orig | input | 1 | Generation status for built word |
| emph | input | 1 | 50/15 us emphasis flag for built word |
| non_audio | input | 1 | Non-audio flag for built word |
| u_in | input | 1 | Serial user bit |
| v_in | input | 1 | Serial validity bit |
| c_bit | output | 1 | Channel status bit of current subframe |
| u_bit | output | 1 | User bit of current subframe |
| v_bit | output | 1 | Validity bit of current subframe |
| sub_right | output | 1 | 1 when the current subframe is right |
| blk_start | output | 1 | High during frame 0 of the 192-frame block |
| bit_stb | output | 1 | One-cycle pulse when new bits are loaded |

## Verification
Random serial bits on every subframe show whether the user, validity and serial status bits are sampled at the right edge and not a half-subframe late. The configuration pins are also re-randomized each subframe. This separates a design that latches the built word only at frame 0 from one that follows the pins. Whole blocks in each mode, plus a block with random mode flips, exercise frame indexing, the wrap at 191 and the block marker. A falling edge right after reset checks that the left/right phase starts correctly.

// File: rtl/csuv_capture.sv
module csuv_capture #(
  parameter int FRAMES = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_clk,
  input  logic serial_mode,
  input  logic copy_c,
  input  logic orig,
  input  logic emph,
  input  logic non_audio,
  input  logic u_in,
  input  logic v_in,
  output logic c_bit,
  output logic u_bit,
  output logic v_bit,
  output logic sub_right,
  output logic blk_start,
  output logic bit_stb
);
  localparam int FW = $clog2(FRAMES);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic s1, s2, s3;
  always_ff @(posedge clk) {s3, s2, s1} <= {s2, s1, word_clk};

  wire rise = rst_n & s2 & ~s3;
  wire fall = rst_n & ~s2 & s3;

  logic              started;
  logic [FW-1:0]     cur_frame, nxt_frame;
  logic [FRAMES-1:0] cs_word, cs_new;

  wire [FW-1:0] nxt_inc = (nxt_frame == LAST) ? '0 : nxt_frame + 1'b1;

  always_comb begin
    cs_new     = '0;
    cs_new[1]  = non_audio;
    cs_new[2]  = copy_c;
    cs_new[3]  = emph;
    cs_new[15] = orig;
  end

  wire built_left = (nxt_frame == '0) ? cs_new[0] : cs_word[nxt_frame];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      cur_frame <= '0;
      nxt_frame <= '0;
      cs_word   <= '0;
      c_bit     <= 1'b0;
      u_bit     <= 1'b0;
      v_bit     <= 1'b0;
      sub_right <= 1'b0;
      blk_start <= 1'b0;
      bit_stb   <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (rise) begin
        started   <= 1'b1;
        cur_frame <= nxt_frame;
        nxt_frame <= nxt_inc;
        if (nxt_frame == '0) cs_word <= cs_new;
        c_bit     <= serial_mode ? copy_c : built_left;
        u_bit     <= u_in;
        v_bit     <= v_in;
        sub_right <= 1'b0;
        blk_start <= (nxt_frame == '0);
        bit_stb   <= 1'b1;
      end else if (fall && started) begin
        c_bit     <= serial_mode ? copy_c : cs_word[cur_frame];
        u_bit     <= u_in;
        v_bit     <= v_in;
        sub_right <= 1'b1;
        bit_stb   <= 1'b1;
      end
    end
  end

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !bit_stb && !c_bit && !u_bit && !v_bit && !blk_start); // R1
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R2
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_frame <= LAST && nxt_frame <= LAST); // R5
  AST_BLK_FRAME0: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> cur_frame == '0); // R5
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && nxt_frame == '0) |=> $stable(cs_word)); // R8
  AST_WORD_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_word[0] && cs_word[14:4] == '0 && cs_word[FRAMES-1:16] == '0); // R6
endmodule

// File: tb/csuv_capture_bench.sv
module csuv_capture_bench;
  logic clk = 0, rst_n = 0, word_clk = 1;
  logic serial_mode = 0, copy_c = 0, orig = 0, emph = 0, non_audio = 0, u_in = 0, v_in = 0;
  logic c_bit, u_bit, v_bit, sub_right, blk_start, bit_stb;
  int tests = 0, fails = 0, stb_cnt = 0, frame = 0;
  bit started = 0;
  logic [191:0] word = '0;

  always #10 clk = ~clk;

  csuv_capture u_csuv_capture (.clk, .rst_n, .word_clk, .serial_mode, .copy_c, .orig, .emph,
    .non_audio, .u_in, .v_in, .c_bit, .u_bit, .v_bit, .sub_right, .blk_start, .bit_stb);

  always @(negedge clk) if (bit_stb) stb_cnt++;

  function automatic logic [191:0] build(logic cp, logic og, logic em, logic na);
    logic [191:0] w = '0;
    w[1] = na; w[2] = cp; w[3] = em; w[15] = og;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic half(logic lvl, bit rnd_mode, logic mode);
    logic ec;
    stb_cnt = 0;
    serial_mode = rnd_mode ? logic'($urandom_range(1)) : mode;
    copy_c = logic'($urandom_range(1)); orig = logic'($urandom_range(1));
    emph = logic'($urandom_range(1)); non_audio = logic'($urandom_range(1));
    u_in = logic'($urandom_range(1)); v_in = logic'($urandom_range(1));
    word_clk = lvl;
    if (lvl) begin
      if (!started) begin started = 1; frame = 0; end
      else frame = (frame + 1) % 192;
      if (frame == 0) word = build(copy_c, orig, emph, non_audio);
    end
    ec = serial_mode ? copy_c : word[frame];
    repeat (2) @(negedge clk);
    chk("R2 latency", int'(bit_stb), 0);
    @(negedge clk);
    chk("R2 strobe", int'(bit_stb), 1);
    repeat (5) @(negedge clk);
    chk("R2 one pulse", stb_cnt, 1);
    chk("R2 side", int'(sub_right), int'(!lvl));
    chk(serial_mode ? "R3 serial c" : "R7 built c", int'(c_bit), int'(ec));
    chk("R4 u", int'(u_bit), int'(u_in));
    chk("R4 v", int'(v_bit), int'(v_in));
    chk("R5 blk_start", int'(blk_start), int'(frame == 0));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    chk("R1 c", int'(c_bit), 0); chk("R1 u", int'(u_bit), 0);
    chk("R1 v", int'(v_bit), 0); chk("R1 blk", int'(blk_start), 0);
    chk("R1 stb", int'(bit_stb), 0);
    rst_n = 1;
    stb_cnt = 0; u_in = 1; v_in = 1;
    word_clk = 0;
    repeat (8) @(negedge clk);
    chk("R1 early fall ignored", stb_cnt, 0);
    chk("R1 u held", int'(u_bit), 0);
    chk("R1 v held", int'(v_bit), 0);
    for (int b = 0; b < 4; b++)
      for (int f = 0; f < 192; f++) begin
        half(1'b1, b == 3, logic'(b == 1));
        half(1'b0, b == 3, logic'(b == 1));
      end
    serial_mode = 0;
    half(1'b1, 0, 0);
    chk("R5 wrap to frame 0", int'(blk_start), 1);
    chk("R6 word layout", int'(c_bit), 0);
    for (int f = 1; f < 16; f++) begin
      half(1'b0, 0, 0);
      half(1'b1, 0, 0);
      if (f == 1 || f == 2 || f == 3 || f == 15)
        chk("R6 field bit", int'(c_bit), int'(word[f]));
      else chk("R6 zero bit", int'(c_bit), 0);
      chk("R8 word latched", int'(c_bit), int'(word[f]));
    end
    chk("R9 mode sampled per edge", int'(serial_mode), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule